// File: doc/BRIEF.md
# Two-Bank Tagged Sample Packer

This block accepts a parallel snapshot of sixteen 16-bit analog samples on a sample strobe and spreads it over two streaming outputs, each 66 bits wide. A snapshot is split into two banks of eight channels. Both output streams serve the low bank in one time slot and the high bank in a later slot. Each output word carries four samples. The two spare bits at the top of a word name the bank and carry the low bit of a running snapshot count. A downstream receiver can therefore sort channel n from channel n+8 by looking at the word alone. It does not have to rely on the order in which words arrive. This holds even when words are stalled or dropped.

A free-running slot counter takes the values 0, 1, 2, 3. The low bank goes out on slot 0 and the high bank on slot 2. Slots 1 and 3 load nothing. Each stream has a valid/ready handshake and a sticky overflow flag. A word that is still waiting is never replaced; if a new word would have to replace it, the new word is discarded instead.

Top module: `sample_bank_packer`

## Requirements
- R1: While `smp_stb` is high at a clock edge, the whole `smp_data` vector is stored as the current snapshot. A later strobe replaces it. The high-bank words of a launched snapshot hold the values that the low-bank words were built from, even if strobes arrive between the two slots.
- R2: After reset is released, the slot counter is 0 at the first clock edge and then advances by one per edge, wrapping 3 to 0. A stream register loads a low-bank word only at a slot-0 edge and a high-bank word only at a slot-2 edge. At slot-1 and slot-3 edges no word is loaded.
- R3: In the word of stream s for bank b, bits [16j+15:16j] hold channel 8b+4s+j, for j = 0 to 3. Channel c sits at bits [16c+15:16c] of `smp_data`. Stream s occupies bits [66s+65:66s] of `out_data`.
- R4: Bit 64 of each word is the bank (0 for channels 0 to 7, 1 for channels 8 to 15). Bit 65 is the low bit of a count of slot-0 edges that found an unsent snapshot, launched or dropped. That count is 0 after reset. Both bank words of one snapshot carry the same bit 65.
- R5: A word is accepted at an edge where its `out_valid` and `out_ready` bits are both high. While `out_valid` is high and `out_ready` is low, the word and its valid bit stay unchanged.
- R6: A snapshot is sent at most once. A slot-0 edge with no snapshot stored since the last slot-0 launch or drop loads nothing.
- R7: At a slot-0 edge with an unsent snapshot, the snapshot is dropped whole if any stream holds a word with `out_ready` low. No word of either bank is produced from it, the pending words stay, and the overflow bit of each blocked stream is set.
- R8: At a slot-2 edge, a stream whose pending word is blocked drops its high-bank word and sets its overflow bit. A stream that is not blocked still loads its high-bank word.
- R9: An overflow bit stays high once set, until reset.
- R10: A synchronous reset clears the slot counter to 0, all valid and overflow bits, the stored snapshot state and the snapshot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe; stores `smp_data` |
| smp_data | input | 256 | Sixteen 16-bit channel samples, channel c at bits [16c+15:16c] |
| out_data | output | 132 | Two 66-bit words, stream s at bits [66s+65:66s] |
| out_valid | output | 2 | Word valid, one bit per stream |
| out_ready | input | 2 | Downstream ready, one bit per stream |
| out_ovf | output | 2 | Sticky overflow, one bit per stream |

## Verification
The hardest case to reach from the ports is a split outcome at the high-bank slot. Here the low-bank words left both streams and one stream is blocked two cycles later while the other drains. This is R8, and it must be told apart from the whole-snapshot drop of R7. The stimulus reaches it in two ways. It drops ready on one stream for a few cycles right after a strobe, and it runs long stretches where ready and strobe are random per cycle. Across those stretches the slot phase, the strobe timing and the blocking pattern fall into every combination. A behavioural model follows each cycle, so every bank tag, count bit and lane is compared whenever a word is valid.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

   // Next value of a slot counter that wraps after last_slot.
   function automatic int unsigned next_slot(input int unsigned cur,
                                             input int unsigned last_slot);
      return (cur == last_slot) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/sbp_slot_ctr.sv
module sbp_slot_ctr #(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [SLOT_W-1:0] slot_o
);
   import sbp_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) slot_o <= '0;
      else     slot_o <= SLOT_W'(next_slot(32'(slot_o), SLOTS - 1));
   end
endmodule

// File: rtl/sbp_snapshot.sv
module sbp_snapshot #(
   parameter int unsigned NUM_CH    = 16,
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned BANKS     = 2,
   parameter int unsigned BANK_BITS = NUM_CH * SAMPLE_W / BANKS
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             stb_i,
   input  logic [NUM_CH*SAMPLE_W-1:0]       din_i,
   input  logic                             go_i,      // slot 0 with unsent snapshot
   input  logic                             launch_i,  // go and nothing blocked
   input  logic [BANKS-2:0]                 clr_pend_i,
   output logic                             fresh_o,
   output logic [BANK_BITS-1:0]             bank0_o,
   output logic [(BANKS-1)*BANK_BITS-1:0]   late_o,
   output logic                             seq_o,
   output logic                             late_seq_o,
   output logic [BANKS-2:0]                 pend_o
);
   localparam int unsigned ALL_W = NUM_CH * SAMPLE_W;

   logic [ALL_W-1:0] hold_q;

   assign bank0_o = hold_q[BANK_BITS-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q     <= '0;
         fresh_o    <= 1'b0;
         seq_o      <= 1'b0;
         late_o     <= '0;
         late_seq_o <= 1'b0;
         pend_o     <= '0;
      end else begin
         if (stb_i) begin
            hold_q  <= din_i;
            fresh_o <= 1'b1;
         end else if (go_i) begin
            fresh_o <= 1'b0;
         end
         if (go_i) seq_o <= ~seq_o;
         if (launch_i) begin
            late_o     <= hold_q[ALL_W-1:BANK_BITS];
            late_seq_o <= seq_o;
            pend_o     <= '1;
         end else begin
            pend_o <= pend_o & ~clr_pend_i;
         end
      end
   end
endmodule

// File: rtl/sbp_out_slot.sv
module sbp_out_slot #(
   parameter int unsigned WORD_W = 66
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              miss_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] data_o,
   output logic              ovf_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         ovf_o   <= 1'b0;
      end else begin
         if (load_i) begin
            valid_o <= 1'b1;
            data_o  <= word_i;
         end else if (ready_i) begin
            valid_o <= 1'b0;
         end
         if (miss_i) ovf_o <= 1'b1;
      end
   end
endmodule

// File: rtl/sample_bank_packer.sv
module sample_bank_packer #(
   parameter int unsigned NUM_CH   = 16,
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned LANES    = 4,
   parameter int unsigned STREAMS  = 2,
   localparam int unsigned PAY_W   = LANES * SAMPLE_W,
   localparam int unsigned BANKS   = NUM_CH / (LANES * STREAMS),
   localparam int unsigned BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int unsigned WORD_W  = PAY_W + BANK_W + 1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        smp_stb,
   input  logic [NUM_CH*SAMPLE_W-1:0]  smp_data,
   output logic [STREAMS*WORD_W-1:0]   out_data,
   output logic [STREAMS-1:0]          out_valid,
   input  logic [STREAMS-1:0]          out_ready,
   output logic [STREAMS-1:0]          out_ovf
);
   localparam int unsigned SLOTS     = 2 * BANKS;
   localparam int unsigned SLOT_W    = $clog2(SLOTS);
   localparam int unsigned BANK_BITS = STREAMS * PAY_W;

   if (NUM_CH % (LANES * STREAMS) != 0) begin : g_bad_split
      $error("channel count must divide evenly into banks");
   end
   if (BANKS < 2) begin : g_bad_banks
      $error("at least two banks are required");
   end

   logic [SLOT_W-1:0]                 slot_q;
   logic                              fresh;
   logic [BANK_BITS-1:0]              bank0_snap;
   logic [(BANKS-1)*BANK_BITS-1:0]    late_snap;
   logic                              seq_now, seq_late;
   logic [BANKS-2:0]                  pend, clr_pend;
   logic                              go, launch, emit_late;
   logic [BANK_W-1:0]                 late_bank;
   logic [STREAMS-1:0]                blocked;

   sbp_slot_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) slot_i (
      .clk(clk), .rst(rst), .slot_o(slot_q)
   );

   sbp_snapshot #(
      .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .BANKS(BANKS), .BANK_BITS(BANK_BITS)
   ) snap_i (
      .clk(clk), .rst(rst), .stb_i(smp_stb), .din_i(smp_data),
      .go_i(go), .launch_i(launch), .clr_pend_i(clr_pend),
      .fresh_o(fresh), .bank0_o(bank0_snap), .late_o(late_snap),
      .seq_o(seq_now), .late_seq_o(seq_late), .pend_o(pend)
   );

   assign blocked = out_valid & ~out_ready;
   assign go      = (slot_q == '0) && fresh;
   assign launch  = go && (blocked == '0);

   // Slot 2b emits bank b (b >= 1) if that bank is still pending.
   always_comb begin
      emit_late = 1'b0;
      clr_pend  = '0;
      late_bank = '0;
      for (int b = 1; b < BANKS; b++) begin
         if (slot_q == SLOT_W'(2 * b)) begin
            clr_pend[b-1] = 1'b1;
            late_bank     = BANK_W'(b);
            if (pend[b-1]) emit_late = 1'b1;
         end
      end
   end

   for (genvar s = 0; s < STREAMS; s++) begin : g_stream
      logic [PAY_W-1:0]  late_pay;
      logic [WORD_W-1:0] word;
      logic              load, miss;

      always_comb begin
         late_pay = '0;
         for (int b = 1; b < BANKS; b++) begin
            if (late_bank == BANK_W'(b))
               late_pay = late_snap[(b-1)*BANK_BITS + s*PAY_W +: PAY_W];
         end
      end

      assign word = launch ? {seq_now,  BANK_W'(0), bank0_snap[s*PAY_W +: PAY_W]}
                           : {seq_late, late_bank,  late_pay};
      assign load = launch || (emit_late && !blocked[s]);
      assign miss = blocked[s] && (go || emit_late);

      sbp_out_slot #(.WORD_W(WORD_W)) out_i (
         .clk(clk), .rst(rst), .load_i(load), .word_i(word), .miss_i(miss),
         .ready_i(out_ready[s]), .valid_o(out_valid[s]),
         .data_o(out_data[s*WORD_W +: WORD_W]), .ovf_o(out_ovf[s])
      );
   end
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
   parameter int unsigned STREAMS = 2,
   parameter int unsigned WORD_W  = 66,
   parameter int unsigned PAY_W   = 64,
   parameter int unsigned BANK_W  = 1,
   parameter int unsigned SLOT_W  = 2
) (
   input logic                      clk,
   input logic                      rst,
   input logic [SLOT_W-1:0]         slot,
   input logic [STREAMS*WORD_W-1:0] out_data,
   input logic [STREAMS-1:0]        out_valid,
   input logic [STREAMS-1:0]        out_ready,
   input logic [STREAMS-1:0]        out_ovf
);
   for (genvar s = 0; s < STREAMS; s++) begin : g_chk
      // R5
      stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
         out_valid[s] && !out_ready[s] |=> out_valid[s] && $stable(out_data[s*WORD_W +: WORD_W]));
      // R9
      ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
         out_ovf[s] |=> out_ovf[s]);
      // R2
      odd_slot_idle_chk: assert property (@(posedge clk) disable iff (rst)
         slot[0] && (!out_valid[s] || out_ready[s]) |=> !out_valid[s]);
      // R4
      bank_tag_chk: assert property (@(posedge clk) disable iff (rst)
         $rose(out_valid[s]) |-> out_data[s*WORD_W + PAY_W +: BANK_W] == BANK_W'($past(slot) >> 1));
      // R7
      ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
         $rose(out_ovf[s]) |-> $past(out_valid[s] && !out_ready[s]));
      // R10
      reset_clear_chk: assert property (@(posedge clk)
         rst |=> !out_valid[s] && !out_ovf[s]);
   end
endmodule

bind sample_bank_packer sbp_checker #(
   .STREAMS(STREAMS), .WORD_W(WORD_W), .PAY_W(PAY_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W)
) chk_i (
   .clk(clk), .rst(rst), .slot(slot_q), .out_data(out_data),
   .out_valid(out_valid), .out_ready(out_ready), .out_ovf(out_ovf)
);

// File: tb/sample_bank_packer_tb_top.sv
module sample_bank_packer_tb_top;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         smp_stb = 1'b0;
   logic [255:0] smp_data = '0;
   logic [131:0] out_data;
   logic [1:0]   out_valid;
   logic [1:0]   out_ready = 2'b11;
   logic [1:0]   out_ovf;

   always #10 clk = ~clk;

   sample_bank_packer dut_i (
      .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_ovf(out_ovf)
   );

   int    n_cmp = 0, n_bad = 0;
   bit    cmp_on = 0, done = 0;
   string tag = "R10";

   // behavioural reference state
   int           m_slot;
   bit           m_fresh, m_pend, m_seq, m_lseq;
   logic [255:0] m_hold, m_late;
   bit    [1:0]  m_valid, m_ovf;
   logic [65:0]  m_data [2];

   function automatic logic [65:0] mk_word(int bank, int s, logic [255:0] snap, bit seq);
      logic [65:0] w;
      for (int j = 0; j < 4; j++) w[j*16 +: 16] = snap[(bank*8 + s*4 + j)*16 +: 16];
      w[64] = bank[0];
      w[65] = seq;
      return w;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_slot = 0; m_fresh = 0; m_pend = 0; m_seq = 0; m_lseq = 0;
         m_hold = '0; m_late = '0; m_valid = '0; m_ovf = '0;
         m_data[0] = '0; m_data[1] = '0;
      end else begin
         bit [1:0] blk;
         blk = m_valid & ~out_ready;
         for (int s = 0; s < 2; s++) if (m_valid[s] && out_ready[s]) m_valid[s] = 0;
         if (m_slot == 0 && m_fresh) begin
            if (blk != 0) m_ovf |= blk;
            else begin
               for (int s = 0; s < 2; s++) begin
                  m_data[s] = mk_word(0, s, m_hold, m_seq);
                  m_valid[s] = 1;
               end
               m_pend = 1; m_late = m_hold; m_lseq = m_seq;
            end
            m_seq = ~m_seq;
            m_fresh = 0;
         end
         if (m_slot == 2 && m_pend) begin
            for (int s = 0; s < 2; s++) begin
               if (blk[s]) m_ovf[s] = 1;
               else begin
                  m_data[s] = mk_word(1, s, m_late, m_lseq);
                  m_valid[s] = 1;
               end
            end
         end
         if (m_slot == 2) m_pend = 0;
         if (smp_stb) begin m_hold = smp_data; m_fresh = 1; end
         m_slot = (m_slot + 1) % 4;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         for (int s = 0; s < 2; s++) begin
            n_cmp++;
            if (out_valid[s] !== m_valid[s]) begin
               n_bad++;
               $display("FAIL %s valid s%0d actual %b expected %b", tag, s, out_valid[s], m_valid[s]);
            end
            n_cmp++;
            if (out_ovf[s] !== m_ovf[s]) begin
               n_bad++;
               $display("FAIL %s ovf s%0d actual %b expected %b", tag, s, out_ovf[s], m_ovf[s]);
            end
            if (m_valid[s]) begin
               n_cmp++;
               if (out_data[s*66 +: 66] !== m_data[s]) begin
                  n_bad++;
                  $display("FAIL %s data s%0d actual %h expected %h", tag, s, out_data[s*66 +: 66], m_data[s]);
               end
            end
         end
      end
   end

   function automatic logic [255:0] pattern(int k);
      logic [255:0] p;
      for (int c = 0; c < 16; c++) p[c*16 +: 16] = {k[7:0], c[7:0]};
      return p;
   endfunction

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(int k);
      smp_data = pattern(k); smp_stb = 1; step(1); smp_stb = 0;
   endtask

   initial begin
      step(3);
      cmp_on = 1;
      tag = "R10"; step(2);
      rst = 0;
      tag = "R3"; strobe(1); step(10); strobe(2); step(9);
      tag = "R1";
      for (int i = 0; i < 6; i++) strobe(16 + i);
      step(2); strobe(30); step(1); strobe(31); step(8);
      tag = "R6"; step(16);
      tag = "R4";
      for (int i = 0; i < 6; i++) begin strobe(40 + i); step(3); end
      step(6);
      tag = "R5"; out_ready = 2'b10; strobe(50); step(3); out_ready = 2'b11; step(8);
      tag = "R8"; strobe(60); step(1);
      for (int i = 0; i < 8; i++) begin out_ready = 2'b01; step(1); end
      out_ready = 2'b11; step(8);
      tag = "R7"; out_ready = 2'b00;
      for (int i = 0; i < 5; i++) begin strobe(70 + i); step(3); end
      tag = "R9"; out_ready = 2'b11; step(12); strobe(80); step(10);
      tag = "R10"; rst = 1; step(2); rst = 0; step(4);
      tag = "R8";
      for (int i = 0; i < 1500; i++) begin
         out_ready = 2'($urandom_range(0, 3));
         smp_stb = ($urandom_range(0, 4) == 0);
         smp_data = pattern(100 + i);
         step(1);
      end
      smp_stb = 0;
      tag = "R2"; out_ready = 2'b11;
      for (int i = 0; i < 300; i++) begin
         smp_stb = (i % 7 == 3);
         smp_data = pattern(i);
         step(1);
      end
      smp_stb = 0; step(8);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule